// File: doc/BRIEF.md
# Digital I/O Port Bank

This block is a bank of byte-wide digital ports behind a simple byte-wide register bus. Each port drives eight output pins with their own output enables and samples eight input pins. A one-bit direction register makes a port an input or an output, and a data register holds the levels the port drives. A build-time option inverts every driven level, so that pins carry the complement of the stored data.

Every input line can be routed through a glitch filter of its own. All filters share one 20-bit interval register, which counts in ticks from a clock prescaler. Each line has a two-state machine. In `FLT_STABLE` the accepted level is held. When the synchronised pin differs from that level, the machine moves to `FLT_PENDING` and starts counting ticks. From `FLT_PENDING` it takes one of three transitions back to `FLT_STABLE`:
- accept: the interval runs out and the new level is taken.
- discard: the pin returns to the accepted level first, and the pulse is dropped.
- bypass: filtering is switched off or the interval is zero, and the pin level is copied straight through.

In `FLT_STABLE` with bypass active, the level follows the pin every cycle. Reads are combinational on the address, and writes take effect at the next clock edge.

Top module: `dio_bank`

## Requirements
- R1: Address 0x00 always reads the parameter `ID_VALUE`. Writes to it change nothing.
- R2: Port p decodes at 0x40 + p*0x10. Offset +0 is data, +1 is direction (bit 0) and +4 is the filter enable. Every other offset in the port window reads 0.
- R3: A direction bit of 1 makes the port an input, with all eight `pin_oe` bits low. A 0 makes it an output, with all eight bits high.
- R4: `pin_out` for a port carries the written data byte when `INVERT_OUT` is 0. It carries the complement when `INVERT_OUT` is 1. This holds one cycle after the write.
- R5: Reading the data register of an output port returns the levels on its `pin_out` bits.
- R6: Reading the data register of an input port returns its accepted input levels. Bit n is pin p*8+n. An unfiltered pin change is visible from the third clock edge after it.
- R7: The filter interval is 20 bits wide. Bits 7:0 are at 0x08 and bits 15:8 at 0x09. Bits 19:16 are in the low nibble of 0x0A, and the upper nibble of 0x0A reads 0. The interval counts ticks of `TICK_DIV` clocks.
- R8: With filtering active on a line, a new level is accepted only at the interval-th tick after the line entered `FLT_PENDING`. A pulse that ends earlier is discarded.
- R9: A filter enable bit affects only its own line. An interval of 0 bypasses every filter.
- R10: After reset, every port is an input, every filter enable is 0, the interval is 0 and the data registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | NUM_PORTS*8 | Input pin levels, port p in bits p*8+7:p*8 |
| pin_out | output | NUM_PORTS*8 | Driven pin levels |
| pin_oe | output | NUM_PORTS*8 | Output enables, 1 drives the pin |

## Verification
The hardest situation to reach is the boundary between a pulse that is discarded and a level that is accepted. Where it falls depends on the tick phase at the moment the line enters `FLT_PENDING`. The stimulus makes ticks frequent by shrinking the divider and sets a small interval. It then drives one pulse that ends well before the earliest possible accept and one level that is held well past the latest possible accept. Meanwhile a neighbouring unfiltered line toggles, to show that the filter enable acts only on its own line. Randomised data and pin patterns cover the plain input and output paths.

// File: rtl/dio_pkg.sv
package dio_pkg;
    localparam int          PORT_BITS   = 8;
    localparam int          FILT_W      = 20;
    localparam int          MAX_PORTS   = 12;
    localparam logic [7:0]  ADDR_ID     = 8'h00;
    localparam logic [7:0]  ADDR_FI0    = 8'h08;
    localparam logic [7:0]  ADDR_FI1    = 8'h09;
    localparam logic [7:0]  ADDR_FI2    = 8'h0A;
    localparam logic [3:0]  PORT_HI0    = 4'h4;
    localparam logic [3:0]  OFS_DATA    = 4'h0;
    localparam logic [3:0]  OFS_DIR     = 4'h1;
    localparam logic [3:0]  OFS_FEN     = 4'h4;

    typedef enum logic {
        FLT_STABLE  = 1'b0,
        FLT_PENDING = 1'b1
    } flt_state_e;
endpackage

// File: rtl/dio_tick_gen.sv
module dio_tick_gen #(
    parameter int TICK_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(TICK_DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/dio_glitch_filter.sv
module dio_glitch_filter
    import dio_pkg::*;
#(
    parameter int FW = FILT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic          en,
    input  logic [FW-1:0] interval,
    input  logic          tick,
    output logic          level
);
    flt_state_e    state, state_n;
    logic [FW-1:0] cnt, cnt_n;
    logic          level_n;
    logic          bypass;
    logic [FW:0]   cnt_inc;

    assign bypass  = !en || (interval == '0);
    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_STABLE;
            cnt   <= '0;
            level <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            level <= level_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        level_n = level;
        unique case (state)
            FLT_STABLE: begin
                if (bypass) begin
                    level_n = raw;
                end else if (raw != level) begin
                    state_n = FLT_PENDING;
                    cnt_n   = '0;
                end
            end
            FLT_PENDING: begin
                if (bypass) begin
                    state_n = FLT_STABLE;
                    level_n = raw;
                end else if (raw == level) begin
                    state_n = FLT_STABLE;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, interval}) begin
                        state_n = FLT_STABLE;
                        level_n = raw;
                    end else begin
                        cnt_n = cnt_inc[FW-1:0];
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/dio_port.sv
module dio_port
    import dio_pkg::*;
#(
    parameter bit INVERT_OUT = 1'b0,
    parameter int FW         = FILT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [FW-1:0]        interval,
    input  logic                 wr_data,
    input  logic                 wr_dir,
    input  logic                 wr_fen,
    input  logic [PORT_BITS-1:0] wdata,
    input  logic [PORT_BITS-1:0] pin_in,
    output logic [PORT_BITS-1:0] pin_out,
    output logic [PORT_BITS-1:0] pin_oe,
    output logic [PORT_BITS-1:0] rd_data,
    output logic                 is_input,
    output logic [PORT_BITS-1:0] fen,
    output logic [PORT_BITS-1:0] level
);
    logic [PORT_BITS-1:0] out_q, sync1, sync2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q    <= '0;
            is_input <= 1'b1;
            fen      <= '0;
            sync1    <= '0;
            sync2    <= '0;
        end else begin
            if (wr_data) out_q    <= wdata;
            if (wr_dir)  is_input <= wdata[0];
            if (wr_fen)  fen      <= wdata;
            sync1 <= pin_in;
            sync2 <= sync1;
        end
    end

    assign pin_out = INVERT_OUT ? ~out_q : out_q;
    assign pin_oe  = {PORT_BITS{~is_input}};
    assign rd_data = is_input ? level : pin_out;

    for (genvar b = 0; b < PORT_BITS; b++) begin : g_bit
        dio_glitch_filter #(.FW(FW)) u_flt (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (sync2[b]),
            .en       (fen[b]),
            .interval (interval),
            .tick     (tick),
            .level    (level[b])
        );
    end
endmodule

// File: rtl/dio_bank.sv
module dio_bank
    import dio_pkg::*;
#(
    parameter int         NUM_PORTS  = 4,
    parameter bit         INVERT_OUT = 1'b0,
    parameter int         TICK_DIV   = 25,
    parameter logic [7:0] ID_VALUE   = 8'h5A
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [7:0]                     bus_addr,
    input  logic                           bus_wr,
    input  logic [7:0]                     bus_wdata,
    output logic [7:0]                     bus_rdata,
    input  logic [NUM_PORTS*PORT_BITS-1:0] pin_in,
    output logic [NUM_PORTS*PORT_BITS-1:0] pin_out,
    output logic [NUM_PORTS*PORT_BITS-1:0] pin_oe
);
    localparam int NB = NUM_PORTS * PORT_BITS;

    logic                 tick;
    logic [FILT_W-1:0]    flt_interval;
    logic [PORT_BITS-1:0] port_rd  [NUM_PORTS];
    logic [PORT_BITS-1:0] port_fen [NUM_PORTS];
    logic                 port_in  [NUM_PORTS];
    logic [NB-1:0]        in_level;
    logic [NB-1:0]        fen_flat;

    dio_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_interval <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_FI0: flt_interval[7:0]   <= bus_wdata;
                ADDR_FI1: flt_interval[15:8]  <= bus_wdata;
                ADDR_FI2: flt_interval[19:16] <= bus_wdata[3:0];
                default:  ;
            endcase
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [3:0] HI = 4'(int'(PORT_HI0) + p);
        logic hit;
        assign hit = bus_wr && (bus_addr[7:4] == HI);

        dio_port #(.INVERT_OUT(INVERT_OUT), .FW(FILT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .interval (flt_interval),
            .wr_data  (hit && bus_addr[3:0] == OFS_DATA),
            .wr_dir   (hit && bus_addr[3:0] == OFS_DIR),
            .wr_fen   (hit && bus_addr[3:0] == OFS_FEN),
            .wdata    (bus_wdata),
            .pin_in   (pin_in[p*PORT_BITS +: PORT_BITS]),
            .pin_out  (pin_out[p*PORT_BITS +: PORT_BITS]),
            .pin_oe   (pin_oe[p*PORT_BITS +: PORT_BITS]),
            .rd_data  (port_rd[p]),
            .is_input (port_in[p]),
            .fen      (port_fen[p]),
            .level    (in_level[p*PORT_BITS +: PORT_BITS])
        );
        assign fen_flat[p*PORT_BITS +: PORT_BITS] = port_fen[p];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_ID:  bus_rdata = ID_VALUE;
            ADDR_FI0: bus_rdata = flt_interval[7:0];
            ADDR_FI1: bus_rdata = flt_interval[15:8];
            ADDR_FI2: bus_rdata = {4'h0, flt_interval[19:16]};
            default:  ;
        endcase
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr[7:4] == 4'(int'(PORT_HI0) + p)) begin
                case (bus_addr[3:0])
                    OFS_DATA: bus_rdata = port_rd[p];
                    OFS_DIR:  bus_rdata = {7'h00, port_in[p]};
                    OFS_FEN:  bus_rdata = port_fen[p];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dio_bank_chk.sv
module dio_bank_chk #(
    parameter bit         INVERT_OUT = 1'b0,
    parameter logic [7:0] ID_VALUE   = 8'h5A,
    parameter int         FW         = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    bus_addr,
    input logic          bus_wr,
    input logic [7:0]    bus_wdata,
    input logic [7:0]    bus_rdata,
    input logic [7:0]    pin_out0,
    input logic [7:0]    pin_oe0,
    input logic          level0,
    input logic          fen0,
    input logic          tick,
    input logic [FW-1:0] flt_interval
);
    // R1
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h00) |-> (bus_rdata == ID_VALUE));

    // R3
    dir_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h41 && !bus_wdata[0]) |=> (pin_oe0 == 8'hFF));

    // R3
    dir_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h41 && bus_wdata[0]) |=> (pin_oe0 == 8'h00));

    // R4
    out_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h40) |=>
            (pin_out0 == (INVERT_OUT ? ~$past(bus_wdata) : $past(bus_wdata))));

    // R10
    reset_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe0 == 8'h00));

    // R8
    filter_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(level0) && $past(fen0) && ($past(flt_interval) != '0)) |-> $past(tick));
endmodule

bind dio_bank dio_bank_chk #(
    .INVERT_OUT (INVERT_OUT),
    .ID_VALUE   (ID_VALUE),
    .FW         (dio_pkg::FILT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pin_out0     (pin_out[7:0]),
    .pin_oe0      (pin_oe[7:0]),
    .level0       (in_level[0]),
    .fen0         (fen_flat[0]),
    .tick         (tick),
    .flt_interval (flt_interval)
);

// File: tb/test_dio_bank.sv
`timescale 1ns/1ps
module test_dio_bank;
    localparam int         NP   = 4;
    localparam bit         INV  = 1'b1;
    localparam int         TDIV = 4;
    localparam logic [7:0] IDV  = 8'hA5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic [NP*8-1:0] pin_in = '0;
    logic [NP*8-1:0] pin_out;
    logic [NP*8-1:0] pin_oe;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dio_bank #(.NUM_PORTS(NP), .INVERT_OUT(INV), .TICK_DIV(TDIV), .ID_VALUE(IDV)) i_dio_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_pin(input logic [7:0] d);
        return INV ? ~d : d;
    endfunction

    function automatic logic [7:0] port_addr(input int p, input logic [3:0] ofs);
        return 8'(8'h40 + p * 16) | {4'h0, ofs};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R0 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v1, v3;
        void'($urandom(32'd20240611));
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R10 reset state
        check("R10 oe", pin_oe, '0);
        for (int p = 0; p < NP; p++) begin
            check("R10 pin_out", pin_out[p*8 +: 8], exp_pin(8'h00));
            rd(port_addr(p, 4'h1), d); check("R10 dir", d, 8'h01);
            rd(port_addr(p, 4'h4), d); check("R10 fen", d, 8'h00);
        end
        rd(8'h08, d); check("R10 interval", d, 8'h00);

        // R1 identification, write ignored
        rd(8'h00, d); check("R1 id", d, IDV);
        wr(8'h00, 8'h3C);
        rd(8'h00, d); check("R1 id after write", d, IDV);

        // R2 unused offsets read zero
        wr(port_addr(2, 4'h2), 8'hFF);
        rd(port_addr(2, 4'h2), d); check("R2 offset2", d, 8'h00);
        rd(port_addr(1, 4'h3), d); check("R2 offset3", d, 8'h00);

        // R3 direction
        wr(port_addr(1, 4'h1), 8'h00);
        wr(port_addr(3, 4'h1), 8'h00);
        check("R3 oe outputs", pin_oe, {8'hFF, 8'h00, 8'hFF, 8'h00});
        rd(port_addr(1, 4'h1), d); check("R3 dir read", d, 8'h00);

        // R4 R5 random output data
        for (int i = 0; i < 20; i++) begin
            v1 = 8'($urandom);
            v3 = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
            wr(port_addr(1, 4'h0), v1);
            wr(port_addr(3, 4'h0), v3);
            check("R4 port1 pins", pin_out[15:8], exp_pin(v1));
            check("R4 port3 pins", pin_out[31:24], exp_pin(v3));
            rd(port_addr(3, 4'h0), d); check("R5 port3 readback", d, exp_pin(v3));
        end

        // R6 random unfiltered inputs on ports 0 and 2
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pin_in = $urandom;
            wait_cyc(4);
            rd(port_addr(0, 4'h0), d); check("R6 port0", d, pin_in[7:0]);
            rd(port_addr(2, 4'h0), d); check("R6 port2", d, pin_in[23:16]);
        end

        // R7 interval register layout
        wr(8'h09, 8'h12);
        rd(8'h09, d); check("R7 byte1", d, 8'h12);
        wr(8'h0A, 8'hF5);
        rd(8'h0A, d); check("R7 byte2 nibble", d, 8'h05);
        wr(8'h09, 8'h00);
        wr(8'h0A, 8'h00);
        wr(8'h08, 8'h03);
        rd(8'h08, d); check("R7 byte0", d, 8'h03);

        // R8 R9 filter on port 0 bit 0 only, interval 3 ticks
        @(negedge clk); pin_in[7:0] = 8'h00;
        wait_cyc(6);
        wr(port_addr(0, 4'h4), 8'h01);
        @(negedge clk); pin_in[7:0] = 8'h03;
        wait_cyc(4);
        rd(port_addr(0, 4'h0), d); check("R9 unfiltered bit passes", d, 8'h02);
        pin_in[7:0] = 8'h00;
        wait_cyc(30);
        rd(port_addr(0, 4'h0), d); check("R8 short pulse dropped", d, 8'h00);

        @(negedge clk); pin_in[7:0] = 8'h01;
        wait_cyc(4);
        rd(port_addr(0, 4'h0), d); check("R8 not yet accepted", d, 8'h00);
        wait_cyc(25);
        rd(port_addr(0, 4'h0), d); check("R8 held level accepted", d, 8'h01);

        // R9 interval zero bypasses filter
        wr(8'h08, 8'h00);
        @(negedge clk); pin_in[7:0] = 8'h00;
        wait_cyc(4);
        rd(port_addr(0, 4'h0), d); check("R9 bypass", d, 8'h00);

        // R3 back to input
        wr(port_addr(1, 4'h1), 8'h01);
        check("R3 port1 input", pin_oe[15:8], 8'h00);

        finish_run();
    end
endmodule